// File: doc/BRIEF.md
# Seconds/minutes watchdog timer

This block is a watchdog timer that sits inside a logical device and is driven through a byte-wide register write/read port. The host loads a 16-bit timeout and selects whether one count step lasts one second or one minute. A local prescaler derives those steps from the input clock. Loading a nonzero count arms the timer. Loading the count again before it runs out is the keepalive. Loading zero stops the timer.

When the count reaches zero from a nonzero load, the block sets a sticky status flag and stops; it does not reload on its own. Depending on three separate enable bits, it can also drive a fixed-length reset pulse on a keyboard-controller style reset line, a fixed-length pulse on a power-good reset line, and a one-cycle timeout event. The event carries a 4-bit line selector for whatever fabric routes it. The host clears the status flag by writing 1 to it.

Top module: `tmo_watchdog`

## Requirements
- R1: After reset, every mapped register reads 0x00 and all outputs are low. The mapped registers are control 0x71, configuration 0x72, count low 0x73 and count high 0x74.
- R2: A read of configuration 0x72 returns the last byte written to it. A read of control 0x71 returns the status flag in bit 0 and zeros in bits 7:1. Reads of 0x73 and 0x74 return bits 7:0 and 15:8 of the live counter. Any other address reads 0x00.
- R3: A write to 0x73 only holds the byte and leaves the counter unchanged. A write to 0x74 loads the counter with {written byte, held low byte}.
- R4: With configuration bit 7 set (seconds), a running counter decrements exactly every CLK_HZ clocks, counted from the clock edge that loaded it.
- R5: With configuration bit 7 clear (minutes), a running counter decrements exactly every CLK_HZ*SEC_PER_MIN clocks.
- R6: Loading a count of zero stops the timer. The counter stays 0, the status flag is not set and no output pulses.
- R7: Loading the count again while the timer runs restarts both the count and the prescaler, so the next decrement is a full step later and no expiry occurs at the old deadline.
- R8: When a running counter steps from 1 to 0, the status flag (control bit 0) becomes 1 on that edge. It stays set, and the counter stays 0 without reloading.
- R9: Writing control with bit 0 = 1 clears the status flag, and writing it with bit 0 = 0 leaves the flag set. If a clear coincides with an expiry, the flag ends up set.
- R10: On expiry, the keyboard reset output (configuration bit 6) and the power-good reset output (configuration bit 4) are each high for exactly RST_CLKS clocks, starting the cycle after the expiry edge. A disabled output stays low.
- R11: On expiry with configuration bit 5 set, the event output is high for exactly one clock. The event line output always equals configuration bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| kbd_rst_o | output | 1 | Keyboard-controller style reset pulse |
| pg_rst_o | output | 1 | Power-good reset pulse |
| evt_o | output | 1 | One-cycle timeout event |
| evt_line_o | output | 4 | Event line selector from configuration |

## Verification
The bench sweeps every count from 1 to 6 under four mixes of the output enables. In each sweep it checks the counter, the flag and all outputs on every cycle up to and after expiry. This catches an off-by-one in the prescaler, a count that expires one step early or late, and a pulse that is one clock short or long. A minute-mode run checks that the 60-step divider is really used and not bypassed.

Directed cases target several failure modes:
- A keepalive landing one cycle before the deadline, which fails if the reload loses to a tick or the prescaler is not restarted.
- A zero load, which fails if zero is treated as a count of 65536.
- A lone low-byte write, which fails if the counter loads early.
- A status clear on the exact expiry edge, which fails if the clear wins.

// File: rtl/tmo_wdt_pkg.sv
package tmo_wdt_pkg;
  localparam int unsigned CNT_W = 16;

  localparam logic [7:0] ADDR_CTRL = 8'h71;
  localparam logic [7:0] ADDR_CFG  = 8'h72;
  localparam logic [7:0] ADDR_CLO  = 8'h73;
  localparam logic [7:0] ADDR_CHI  = 8'h74;

  typedef struct packed {
    logic       sec_mode;
    logic       kbd_en;
    logic       evt_en;
    logic       pg_en;
    logic [3:0] line;
  } cfg_t;
endpackage

// File: rtl/tmo_wdt_regs.sv
module tmo_wdt_regs
  import tmo_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] cnt_i,
  output cfg_t             cfg_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             status_o,
  output logic [7:0]       rdata_o
);
  logic [7:0] lo_q;
  cfg_t       cfg_q;
  logic       status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      cfg_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_CLO) lo_q  <= wdata_i;
      if (we_i && addr_i == ADDR_CFG) cfg_q <= cfg_t'(wdata_i);
      // set has priority over clear
      if (expire_i)                                       status_q <= 1'b1;
      else if (we_i && addr_i == ADDR_CTRL && wdata_i[0]) status_q <= 1'b0;
    end
  end

  assign load_o     = we_i && (addr_i == ADDR_CHI);
  assign load_val_o = {wdata_i, lo_q};
  assign cfg_o      = cfg_q;
  assign status_o   = status_q;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {7'd0, status_q};
      ADDR_CFG:  rdata_o = cfg_q;
      ADDR_CLO:  rdata_o = cnt_i[7:0];
      ADDR_CHI:  rdata_o = cnt_i[15:8];
      default:   rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/tmo_wdt_prescale.sv
module tmo_wdt_prescale #(
  parameter int unsigned CLK_HZ      = 1000000,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic sec_mode_i,
  output logic unit_tick_o
);
  localparam int unsigned SEC_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam int unsigned MIN_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(CLK_HZ - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SEC_PER_MIN - 1);

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic             sec_tick, min_tick;

  assign sec_tick = run_i && (sec_q == SEC_LAST);
  assign min_tick = sec_tick && (min_q == MIN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (restart_i) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (run_i) begin
      sec_q <= sec_tick ? '0 : sec_q + 1'b1;
      if (sec_tick) min_q <= min_tick ? '0 : min_q + 1'b1;
    end
  end

  assign unit_tick_o = sec_mode_i ? sec_tick : min_tick;
endmodule

// File: rtl/tmo_wdt_count.sv
module tmo_wdt_count
  import tmo_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q && tick_i && !load_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= (load_val_i != '0);
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/tmo_wdt_pulse.sv
module tmo_wdt_pulse #(
  parameter int unsigned RST_CLKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic kbd_en_i,
  input  logic pg_en_i,
  input  logic evt_en_i,
  output logic kbd_rst_o,
  output logic pg_rst_o,
  output logic evt_o
);
  localparam int unsigned RST_W = $clog2(RST_CLKS + 1);

  logic [RST_W-1:0] len_q;
  logic             kbd_q, pg_q, evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      kbd_q <= 1'b0;
      pg_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= fire_i && evt_en_i;
      if (fire_i) begin
        len_q <= RST_W'(RST_CLKS);
        kbd_q <= kbd_en_i;
        pg_q  <= pg_en_i;
      end else if (len_q != '0) begin
        len_q <= len_q - 1'b1;
      end
    end
  end

  assign kbd_rst_o = (len_q != '0) && kbd_q;
  assign pg_rst_o  = (len_q != '0) && pg_q;
  assign evt_o     = evt_q;
endmodule

// File: rtl/tmo_watchdog.sv
module tmo_watchdog
  import tmo_wdt_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 1000000,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned RST_CLKS    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       kbd_rst_o,
  output logic       pg_rst_o,
  output logic       evt_o,
  output logic [3:0] evt_line_o
);
  cfg_t             cfg_w;
  logic             load_w, run_w, expire_w, status_w, tick_w;
  logic [CNT_W-1:0] load_val_w, cnt_w;

  tmo_wdt_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .expire_i   (expire_w),
    .cnt_i      (cnt_w),
    .cfg_o      (cfg_w),
    .load_o     (load_w),
    .load_val_o (load_val_w),
    .status_o   (status_w),
    .rdata_o    (reg_rdata_o)
  );

  tmo_wdt_prescale #(.CLK_HZ(CLK_HZ), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (load_w),
    .run_i       (run_w),
    .sec_mode_i  (cfg_w.sec_mode),
    .unit_tick_o (tick_w)
  );

  tmo_wdt_count u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .tick_i     (tick_w),
    .cnt_o      (cnt_w),
    .run_o      (run_w),
    .expire_o   (expire_w)
  );

  tmo_wdt_pulse #(.RST_CLKS(RST_CLKS)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (expire_w),
    .kbd_en_i  (cfg_w.kbd_en),
    .pg_en_i   (cfg_w.pg_en),
    .evt_en_i  (cfg_w.evt_en),
    .kbd_rst_o (kbd_rst_o),
    .pg_rst_o  (pg_rst_o),
    .evt_o     (evt_o)
  );

  assign evt_line_o = cfg_w.line;
endmodule

// File: rtl/tmo_watchdog_chk.sv
module tmo_watchdog_chk
  import tmo_wdt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [7:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             kbd_rst_o,
  input logic             pg_rst_o,
  input logic             evt_o,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             expire,
  input logic             status
);
  logic clr_wr;
  assign clr_wr = reg_we_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[0];

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> cnt == $past(load_val)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !load) |=> $stable(cnt)); // R6
  AST_EXPIRE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (status && cnt == '0 && !run)); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status && !clr_wr) |=> status); // R8
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !expire) |=> !status); // R9
  AST_KBD_FROM_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kbd_rst_o) |-> $past(expire)); // R10
  AST_PG_FROM_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_rst_o) |-> $past(expire)); // R10
  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R11
endmodule

bind tmo_watchdog tmo_watchdog_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .kbd_rst_o   (kbd_rst_o),
  .pg_rst_o    (pg_rst_o),
  .evt_o       (evt_o),
  .load        (load_w),
  .load_val    (load_val_w),
  .cnt         (cnt_w),
  .run         (run_w),
  .expire      (expire_w),
  .status      (status_w)
);

// File: tb/tmo_watchdog_tb.sv
module tmo_watchdog_tb;
  localparam int P   = 3;
  localparam int SPM = 60;
  localparam int RC  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       kbd, pg, evt;
  logic [3:0] line;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  tmo_watchdog #(.CLK_HZ(P), .SEC_PER_MIN(SPM), .RST_CLKS(RC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .kbd_rst_o(kbd),
    .pg_rst_o(pg), .evt_o(evt), .evt_line_o(line)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic load(input int v);
    wr(8'h73, v[7:0]);
    wr(8'h74, v[15:8]);
  endtask

  // seconds/minutes sweep from load to past the pulse
  task automatic sweep(input logic [7:0] cfg, input int n, input string req);
    int unit;
    logic [7:0] lo, st;
    unit = cfg[7] ? P : P * SPM;
    wr(8'h72, cfg);
    load(n);
    for (int j = 0; j <= unit * n + RC + 2; j++) begin
      peek(8'h73, lo);
      peek(8'h71, st);
      chk({req, " cnt"}, lo, (n - j / unit) < 0 ? 0 : n - j / unit);
      chk("R8 status", st, (j >= unit * n) ? 1 : 0);
      chk("R10 kbd", kbd, (cfg[6] && j >= unit * n && j < unit * n + RC) ? 1 : 0);
      chk("R10 pg", pg, (cfg[4] && j >= unit * n && j < unit * n + RC) ? 1 : 0);
      chk("R11 evt", evt, (cfg[5] && j == unit * n) ? 1 : 0);
      chk("R11 line", line, cfg[3:0]);
      @(negedge clk);
    end
    wr(8'h71, 8'h01);
    peek(8'h71, st);
    chk("R9 clear", st, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(8'h71, d); chk("R1 ctrl", d, 0);
    peek(8'h72, d); chk("R1 cfg", d, 0);
    peek(8'h73, d); chk("R1 clo", d, 0);
    peek(8'h74, d); chk("R1 chi", d, 0);
    chk("R1 outs", {kbd, pg, evt}, 0);
    // R2 map
    wr(8'h72, 8'h5C);
    peek(8'h72, d); chk("R2 cfg readback", d, 8'h5C);
    peek(8'h70, d); chk("R2 unmapped 70", d, 0);
    peek(8'h75, d); chk("R2 unmapped 75", d, 0);
    wr(8'h71, 8'hFE);
    peek(8'h71, d); chk("R2 ctrl upper", d, 0);
    // R3 low byte alone does not load
    wr(8'h72, 8'h80);
    wr(8'h73, 8'h5A);
    peek(8'h73, d); chk("R3 lo only", d, 0);
    wr(8'h74, 8'h01);
    peek(8'h73, d); peek(8'h74, d2);
    chk("R3 full load", {d2, d}, 16'h015A);
    // 16-bit boundary: R4
    load(16'hFFFF);
    peek(8'h73, d); peek(8'h74, d2);
    chk("R4 max load", {d2, d}, 16'hFFFF);
    repeat (P) @(negedge clk);
    peek(8'h73, d); peek(8'h74, d2);
    chk("R4 max step", {d2, d}, 16'hFFFE);
    // R6 zero load stops
    load(0);
    for (int j = 0; j < P * 8; j++) begin
      peek(8'h73, d); peek(8'h71, d2);
      chk("R6 cnt", d, 0);
      chk("R6 status", d2, 0);
      chk("R6 outs", {kbd, pg, evt}, 0);
      @(negedge clk);
    end
    // R4 R8 R10 R11 sweeps over counts and enable mixes
    for (int n = 1; n <= 6; n++) begin
      sweep(8'hC5, n, "R4");
      sweep(8'hB3, n, "R4");
      sweep(8'h9A, n, "R4");
      sweep(8'hE0, n, "R4");
    end
    // R5 minute mode
    sweep(8'h70, 2, "R5");
    // R7 keepalive one cycle before the deadline
    wr(8'h72, 8'hC0);
    load(3);
    repeat (P * 3 - 3) @(negedge clk);
    wr(8'h74, 8'h00);
    for (int j = 0; j <= P * 3; j++) begin
      peek(8'h73, d); peek(8'h71, d2);
      chk("R7 cnt", d, 3 - j / P);
      chk("R7 status", d2, (j >= P * 3) ? 1 : 0);
      chk("R7 kbd", kbd, (j == P * 3) ? 1 : 0);
      @(negedge clk);
    end
    // R9 write 0 keeps flag, then clear
    wr(8'h71, 8'h00);
    peek(8'h71, d); chk("R9 write0 keeps", d, 1);
    wr(8'h71, 8'h01);
    peek(8'h71, d); chk("R9 w1c", d, 0);
    // R9 clear on expiry edge: set wins
    load(1);
    repeat (P - 2) @(negedge clk);
    wr(8'h71, 8'h01);
    peek(8'h71, d); chk("R9 set wins", d, 1);
    peek(8'h73, d); chk("R8 no reload", d, 0);
    repeat (P * 4) @(negedge clk);
    peek(8'h73, d); chk("R8 stays zero", d, 0);
    peek(8'h71, d); chk("R8 sticky", d, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule